// File: doc/BRIEF.md
# E1 Remote Alarm Bit Controller

This block owns the remote alarm indication bit of the E1 service word in both directions. It is placed beside an E1 framer, which supplies the timing strobes and the alignment status. On the receive side it watches the timeslot-0 byte of each aligned non-alignment frame. When the far end starts signalling a remote alarm, it raises a sticky interrupt flag. It only does this while the local receiver holds frame alignment, so a search phase cannot produce false alarms.

On the transmit side it decides, once per outgoing service word, which value the remote alarm bit carries. A transparent mode takes the bit from the system side unchanged. Otherwise the bit is 1 when a manual alarm control is set, or when automatic mode is enabled and the local receiver reports loss of frame alignment. The chosen value is held between service words. Framing and frame alignment search are outside this block.

The receive monitor is a three-state machine. RX_HUNT is entered from any state whenever loss of alignment is reported. HUNT_TO_QUIET is taken one cycle after alignment returns. QUIET_TO_ALARM is taken on a strobe with the alarm bit at 1, and this transition is the only one that raises the interrupt. ALARM_TO_QUIET is taken on a strobe with the alarm bit at 0. The transmit side is a two-state machine, TX_SEND0 and TX_SEND1. Its SEND_UPDATE transition happens only on a transmit strobe, and the selected source picks the next state.

Top module: `rai_bit_ctrl`

## Requirements
- R1: After reset `tx_a_bit` is 0, `ra_irq` is 0, and the receive monitor is in RX_HUNT.
- R2: The alarm bit is bit position 3, counting from 1 at the first-sent most significant bit of the timeslot-0 byte, which is `rx_sw_byte[5]`. Other byte bits never affect detection. `tx_a_bit` changes only in the cycle after a `tx_sw_stb` pulse and holds otherwise.
- R3: On a transmit strobe with `cfg_transp`=1, `tx_a_bit` becomes the value of `sys_a_bit`, whatever the manual and automatic controls are.
- R4: On a transmit strobe with `cfg_transp`=0 and `cfg_man_rai`=1, `tx_a_bit` becomes 1.
- R5: On a transmit strobe with `cfg_transp`=0, `cfg_auto_rai`=1 and `rx_lfa`=1, `tx_a_bit` becomes 1.
- R6: On a transmit strobe with `cfg_transp`=0 and `cfg_man_rai`=0, where either `cfg_auto_rai`=0 or `rx_lfa`=0, `tx_a_bit` becomes 0. This is how automatic mode releases the alarm once alignment returns.
- R7: In the aligned quiet state, a receive strobe with the alarm bit at 1 and `rx_lfa`=0 sets `ra_irq` in the next cycle.
- R8: Receive strobes are ignored while `rx_lfa`=1, and also in the first cycle in which `rx_lfa` returns to 0.
- R9: A continuing far-end alarm does not set the interrupt again. The interrupt can be set again only after a strobe with the alarm bit at 0, or after a loss-of-alignment episode.
- R10: `ra_irq` stays set until a cycle with `ra_irq_clr`=1. If a new alarm detection arrives in the same cycle as the clear, the flag stays set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rx_sw_stb | input | 1 | One-cycle pulse: `rx_sw_byte` holds an aligned service word |
| rx_sw_byte | input | 8 | Received timeslot-0 byte of a non-alignment frame |
| rx_lfa | input | 1 | Local receiver loss of frame alignment |
| tx_sw_stb | input | 1 | One-cycle pulse: outgoing service word alarm bit is latched |
| sys_a_bit | input | 1 | Alarm bit from the system side, used in transparent mode |
| cfg_man_rai | input | 1 | Manual remote alarm transmit control |
| cfg_auto_rai | input | 1 | Automatic alarm-on-loss-of-alignment enable |
| cfg_transp | input | 1 | Transmit transparency for the alarm bit |
| ra_irq_clr | input | 1 | Write-one-to-clear pulse for the interrupt flag |
| tx_a_bit | output | 1 | Outgoing alarm bit value |
| ra_irq | output | 1 | Sticky remote alarm interrupt flag |

## Verification
Every cycle, the assertions check the transmit side: the bit holds between strobes, and on each strobe it follows transparency, the manual control, automatic mode and the release rule. They also check that the interrupt flag stays set until cleared, that a clear takes effect when there is no detection, and that no set occurs while alignment is lost or without a strobe carrying the alarm bit. Some behaviours depend on the hidden receive state, and only the bench scenarios can show them. These are the edge-only set on the quiet-to-alarm transition, the suppression of a continuing alarm, the re-arming after a zero bit or an alignment loss, the first-cycle requalification after alignment returns, and set winning over a simultaneous clear. The bench reference model tracks that state and compares both outputs on every clock.

// File: rtl/rai_pkg.sv
package rai_pkg;

    typedef enum logic [1:0] {
        RX_HUNT  = 2'd0,
        RX_QUIET = 2'd1,
        RX_ALARM = 2'd2
    } rx_state_e;

    typedef enum logic {
        TX_SEND0 = 1'b0,
        TX_SEND1 = 1'b1
    } tx_state_e;

    typedef enum logic [1:0] {
        SRC_SYS   = 2'd0,
        SRC_FORCE = 2'd1,
        SRC_ZERO  = 2'd2
    } tx_src_e;

endpackage

// File: rtl/rai_rx_monitor.sv
module rai_rx_monitor
    import rai_pkg::*;
#(
    parameter int SW_W  = 8,
    parameter int A_POS = 5
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            sw_stb,
    input  logic [SW_W-1:0] sw_byte,
    input  logic            lfa,
    output logic            ra_event
);

    rx_state_e state_q;
    rx_state_e state_d;
    logic      a_bit;

    assign a_bit = sw_byte[A_POS];

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= RX_HUNT;
        end else begin
            state_q <= state_d;
        end
    end

    // next-state logic
    always_comb begin
        state_d = state_q;
        if (lfa) begin
            state_d = RX_HUNT;
        end else begin
            unique case (state_q)
                RX_HUNT:  state_d = RX_QUIET;
                RX_QUIET: if (sw_stb && a_bit)  state_d = RX_ALARM;
                RX_ALARM: if (sw_stb && !a_bit) state_d = RX_QUIET;
                default:  state_d = RX_HUNT;
            endcase
        end
    end

    // output: one-cycle event on the quiet-to-alarm transition only
    always_comb begin
        ra_event = 1'b0;
        unique case (state_q)
            RX_QUIET: ra_event = sw_stb && a_bit && !lfa;
            RX_HUNT,
            RX_ALARM: ra_event = 1'b0;
            default:  ra_event = 1'b0;
        endcase
    end

endmodule

// File: rtl/rai_tx_source.sv
module rai_tx_source
    import rai_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic sw_stb,
    input  logic sys_a,
    input  logic man_rai,
    input  logic auto_rai,
    input  logic lfa,
    input  logic transp,
    output logic a_bit
);

    tx_state_e state_q;
    tx_state_e state_d;
    tx_src_e   src;

    // source selection: transparency first, then manual or automatic alarm
    always_comb begin
        if (transp) begin
            src = SRC_SYS;
        end else if (man_rai || (auto_rai && lfa)) begin
            src = SRC_FORCE;
        end else begin
            src = SRC_ZERO;
        end
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= TX_SEND0;
        end else begin
            state_q <= state_d;
        end
    end

    // next-state logic: update only on the service-word strobe
    always_comb begin
        state_d = state_q;
        if (sw_stb) begin
            unique case (src)
                SRC_SYS:   state_d = sys_a ? TX_SEND1 : TX_SEND0;
                SRC_FORCE: state_d = TX_SEND1;
                SRC_ZERO:  state_d = TX_SEND0;
                default:   state_d = TX_SEND0;
            endcase
        end
    end

    // output
    always_comb begin
        unique case (state_q)
            TX_SEND1: a_bit = 1'b1;
            TX_SEND0: a_bit = 1'b0;
            default:  a_bit = 1'b0;
        endcase
    end

endmodule

// File: rtl/rai_irq_latch.sv
module rai_irq_latch (
    input  logic clk,
    input  logic rst_n,
    input  logic set_ev,
    input  logic clr,
    output logic flag
);

    // set takes precedence over a simultaneous clear
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flag <= 1'b0;
        end else if (set_ev) begin
            flag <= 1'b1;
        end else if (clr) begin
            flag <= 1'b0;
        end
    end

endmodule

// File: rtl/rai_bit_ctrl.sv
module rai_bit_ctrl #(
    parameter int SW_W  = 8,
    parameter int A_POS = 5
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            rx_sw_stb,
    input  logic [SW_W-1:0] rx_sw_byte,
    input  logic            rx_lfa,
    input  logic            tx_sw_stb,
    input  logic            sys_a_bit,
    input  logic            cfg_man_rai,
    input  logic            cfg_auto_rai,
    input  logic            cfg_transp,
    input  logic            ra_irq_clr,
    output logic            tx_a_bit,
    output logic            ra_irq
);

    logic ra_event;

    rai_rx_monitor #(
        .SW_W  (SW_W),
        .A_POS (A_POS)
    ) rx_mon_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .sw_stb   (rx_sw_stb),
        .sw_byte  (rx_sw_byte),
        .lfa      (rx_lfa),
        .ra_event (ra_event)
    );

    rai_irq_latch irq_i (
        .clk    (clk),
        .rst_n  (rst_n),
        .set_ev (ra_event),
        .clr    (ra_irq_clr),
        .flag   (ra_irq)
    );

    rai_tx_source tx_src_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .sw_stb   (tx_sw_stb),
        .sys_a    (sys_a_bit),
        .man_rai  (cfg_man_rai),
        .auto_rai (cfg_auto_rai),
        .lfa      (rx_lfa),
        .transp   (cfg_transp),
        .a_bit    (tx_a_bit)
    );

endmodule

// File: rtl/rai_bit_ctrl_chk.sv
module rai_bit_ctrl_chk #(
    parameter int SW_W  = 8,
    parameter int A_POS = 5
) (
    input logic            clk,
    input logic            rst_n,
    input logic            rx_sw_stb,
    input logic [SW_W-1:0] rx_sw_byte,
    input logic            rx_lfa,
    input logic            tx_sw_stb,
    input logic            sys_a_bit,
    input logic            cfg_man_rai,
    input logic            cfg_auto_rai,
    input logic            cfg_transp,
    input logic            ra_irq_clr,
    input logic            tx_a_bit,
    input logic            ra_irq
);

    logic rx_a;
    logic byte_unused;

    assign rx_a        = rx_sw_byte[A_POS];
    assign byte_unused = ^rx_sw_byte;

    p_tx_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !tx_sw_stb |=> $stable(tx_a_bit));

    p_transp_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_sw_stb && cfg_transp) |=> (tx_a_bit == $past(sys_a_bit)));

    p_manual_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_sw_stb && !cfg_transp && cfg_man_rai) |=> tx_a_bit);

    p_auto_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_sw_stb && !cfg_transp && cfg_auto_rai && rx_lfa) |=> tx_a_bit);

    p_release_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_sw_stb && !cfg_transp && !cfg_man_rai && (!cfg_auto_rai || !rx_lfa))
        |=> !tx_a_bit);

    p_no_set_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (!ra_irq && (rx_lfa || !rx_sw_stb || !rx_a)) |=> !ra_irq);

    p_sticky_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (ra_irq && !ra_irq_clr) |=> ra_irq);

    p_clear_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (ra_irq_clr && (rx_lfa || !rx_sw_stb || !rx_a)) |=> !ra_irq);

endmodule

bind rai_bit_ctrl rai_bit_ctrl_chk #(
    .SW_W  (SW_W),
    .A_POS (A_POS)
) chk_i (
    .clk          (clk),
    .rst_n        (rst_n),
    .rx_sw_stb    (rx_sw_stb),
    .rx_sw_byte   (rx_sw_byte),
    .rx_lfa       (rx_lfa),
    .tx_sw_stb    (tx_sw_stb),
    .sys_a_bit    (sys_a_bit),
    .cfg_man_rai  (cfg_man_rai),
    .cfg_auto_rai (cfg_auto_rai),
    .cfg_transp   (cfg_transp),
    .ra_irq_clr   (ra_irq_clr),
    .tx_a_bit     (tx_a_bit),
    .ra_irq       (ra_irq)
);

// File: tb/rai_bit_ctrl_tb_top.sv
`timescale 1ns/1ps
module rai_bit_ctrl_tb_top;

    logic       clk = 1'b0;
    logic       rst_n;
    logic       rx_sw_stb;
    logic [7:0] rx_sw_byte;
    logic       rx_lfa;
    logic       tx_sw_stb;
    logic       sys_a_bit;
    logic       cfg_man_rai;
    logic       cfg_auto_rai;
    logic       cfg_transp;
    logic       ra_irq_clr;
    logic       tx_a_bit;
    logic       ra_irq;

    int    n_tests = 0;
    int    n_fail  = 0;
    int    cycles  = 0;
    string phase   = "R1";

    // reference model state: 0 hunt, 1 aligned quiet, 2 far-end alarm seen
    int m_rx  = 0;
    int m_tx  = 0;
    int m_irq = 0;

    always #4 clk = ~clk;  // 125 MHz

    rai_bit_ctrl dut_i (
        .clk          (clk),
        .rst_n        (rst_n),
        .rx_sw_stb    (rx_sw_stb),
        .rx_sw_byte   (rx_sw_byte),
        .rx_lfa       (rx_lfa),
        .tx_sw_stb    (tx_sw_stb),
        .sys_a_bit    (sys_a_bit),
        .cfg_man_rai  (cfg_man_rai),
        .cfg_auto_rai (cfg_auto_rai),
        .cfg_transp   (cfg_transp),
        .ra_irq_clr   (ra_irq_clr),
        .tx_a_bit     (tx_a_bit),
        .ra_irq       (ra_irq)
    );

    task automatic check(input string req, input int act, input int exp);
        n_tests++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
        end
    endtask

    // behavioural reference, updated on each rising edge
    always @(posedge clk) begin
        int a;
        a = int'(rx_sw_byte[5]);
        if (!rst_n) begin
            m_rx = 0; m_tx = 0; m_irq = 0;
        end else begin
            if (rx_sw_stb && !rx_lfa && m_rx == 1 && a == 1) m_irq = 1;
            else if (ra_irq_clr) m_irq = 0;
            if (rx_lfa) m_rx = 0;
            else if (m_rx == 0) m_rx = 1;
            else if (rx_sw_stb && m_rx == 1 && a == 1) m_rx = 2;
            else if (rx_sw_stb && m_rx == 2 && a == 0) m_rx = 1;
            if (tx_sw_stb) begin
                if (cfg_transp) m_tx = int'(sys_a_bit);
                else if (cfg_man_rai || (cfg_auto_rai && rx_lfa)) m_tx = 1;
                else m_tx = 0;
            end
        end
    end

    // per-cycle comparison away from the active edge
    always @(negedge clk) begin
        if (rst_n) begin
            check({phase, " model tx"}, int'(tx_a_bit), m_tx);
            check({phase, " model irq"}, int'(ra_irq), m_irq);
        end
    end

    always @(posedge clk) begin
        cycles++;
        if (cycles > 20000) begin
            n_fail++;
            n_tests++;
            $display("FAIL watchdog: actual %0d expected <20000 cycles", cycles);
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic tx_pulse();
        tx_sw_stb = 1'b1;
        @(negedge clk);
        tx_sw_stb = 1'b0;
    endtask

    task automatic rx_pulse(input logic [7:0] b, input logic clr);
        rx_sw_byte = b;
        rx_sw_stb  = 1'b1;
        ra_irq_clr = clr;
        @(negedge clk);
        rx_sw_stb  = 1'b0;
        ra_irq_clr = 1'b0;
    endtask

    initial begin
        rst_n = 1'b0; rx_sw_stb = 1'b0; rx_sw_byte = 8'h00; rx_lfa = 1'b1;
        tx_sw_stb = 1'b0; sys_a_bit = 1'b0; cfg_man_rai = 1'b0;
        cfg_auto_rai = 1'b0; cfg_transp = 1'b0; ra_irq_clr = 1'b0;
        cyc(3);
        rst_n = 1'b1;
        cyc(1);
        check("R1 tx after reset", int'(tx_a_bit), 0);
        check("R1 irq after reset", int'(ra_irq), 0);

        phase = "R3";
        cfg_transp = 1'b1; sys_a_bit = 1'b1;
        tx_pulse();
        check("R3 transparent one", int'(tx_a_bit), 1);
        sys_a_bit = 1'b0; cfg_man_rai = 1'b1; cfg_auto_rai = 1'b1;
        tx_pulse();
        check("R3 transparent overrides manual/auto", int'(tx_a_bit), 0);

        phase = "R2";
        sys_a_bit = 1'b1;
        cyc(3);
        check("R2 hold without strobe", int'(tx_a_bit), 0);

        phase = "R4";
        cfg_transp = 1'b0; cfg_auto_rai = 1'b0;
        tx_pulse();
        check("R4 manual alarm", int'(tx_a_bit), 1);

        phase = "R5";
        cfg_man_rai = 1'b0; cfg_auto_rai = 1'b1; rx_lfa = 1'b1;
        tx_pulse();
        check("R5 auto on loss", int'(tx_a_bit), 1);
        rx_lfa = 1'b0;
        cyc(1);
        check("R2 held until strobe", int'(tx_a_bit), 1);

        phase = "R6";
        tx_pulse();
        check("R6 auto release on sync", int'(tx_a_bit), 0);
        cfg_auto_rai = 1'b0; rx_lfa = 1'b1;
        tx_pulse();
        check("R6 auto disabled", int'(tx_a_bit), 0);

        phase = "R7";
        rx_lfa = 1'b0;
        cyc(2);
        rx_pulse(8'hDF, 1'b0);
        check("R2 other byte bits ignored", int'(ra_irq), 0);
        rx_pulse(8'h20, 1'b0);
        check("R7 alarm detected", int'(ra_irq), 1);

        phase = "R10";
        cyc(3);
        check("R10 sticky", int'(ra_irq), 1);
        ra_irq_clr = 1'b1;
        cyc(1);
        ra_irq_clr = 1'b0;
        check("R10 write-one clear", int'(ra_irq), 0);

        phase = "R9";
        rx_pulse(8'h20, 1'b0);
        check("R9 continuing alarm no re-set", int'(ra_irq), 0);
        rx_pulse(8'h00, 1'b0);
        rx_pulse(8'h20, 1'b0);
        check("R9 re-armed by zero bit", int'(ra_irq), 1);

        phase = "R10";
        ra_irq_clr = 1'b1;
        cyc(1);
        ra_irq_clr = 1'b0;
        rx_pulse(8'h00, 1'b0);
        rx_pulse(8'h20, 1'b1);
        check("R10 set wins over clear", int'(ra_irq), 1);
        ra_irq_clr = 1'b1;
        cyc(1);
        ra_irq_clr = 1'b0;

        phase = "R8";
        rx_lfa = 1'b1;
        cyc(1);
        rx_pulse(8'h00, 1'b0);
        rx_pulse(8'h20, 1'b0);
        check("R8 ignored during loss", int'(ra_irq), 0);
        rx_lfa = 1'b0;
        rx_pulse(8'h20, 1'b0);
        check("R8 ignored in first aligned cycle", int'(ra_irq), 0);
        rx_pulse(8'h20, 1'b0);
        check("R9 re-armed after loss episode", int'(ra_irq), 1);

        cyc(2);
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule